// File: doc/BRIEF.md
# Jitter Buffer Clock Rate Adjuster

This block produces the read-side clock enable of a jitter attenuation elastic buffer. It runs from a reference clock at sixteen times the line bit rate. In steady state it raises its enable once every 16 reference cycles, so the buffer drains at the nominal bit rate. The fill level of the buffer is an input. When the fill level nears the top or the bottom of the buffer, the block shortens or stretches one divide period to pull the read rate toward the write rate.

A shorter period of 15 cycles drains a nearly full buffer faster. A longer period of 17 cycles lets a nearly empty buffer refill. The block decides the length of each period once, at the start of that period, so no enable interval is ever cut short. Every period that does not last 16 cycles sets a sticky limit-trip flag. The host clears the flag with a one-cycle strobe. A mode pin chooses between a 128-bit buffer and a 32-bit buffer, and the near-full threshold depends on that choice.

Top module: `jitter_rate_adjuster`

## Requirements
- R1: While reset is held, and right after it, `rd_en` is 0 and `trip_flag` is 0.
- R2: When the fill level lies strictly between 4 and (depth − 4), `rd_en` pulses once every 16 clock cycles.
- R3: When the fill level is at or above (depth − 4), the next divide period is 15 cycles.
- R4: When the fill level is 4 or below, the next divide period is 17 cycles.
- R5: `deep_mode` = 1 selects a depth of 128 and `deep_mode` = 0 selects a depth of 32. In the 32 mode, a fill level above 32 counts as near full.
- R6: The block samples the fill level only in the cycle where `rd_en` is 1. A change of fill during a period does not change the length of that period.
- R7: Every period of 15 or 17 cycles sets `trip_flag` at the clock edge that starts the period. The flag then stays set through later periods of 16 cycles.
- R8: A `trip_clr` pulse clears `trip_flag` on the next edge. If a 15- or 17-cycle period starts on the same edge, setting wins.
- R9: `rd_en` is a single-cycle pulse. It is high in the last cycle of each period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 16× the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| deep_mode | input | 1 | 1 = 128-bit buffer, 0 = 32-bit buffer |
| fill_lvl | input | 8 | Current buffer fill level in bits |
| trip_clr | input | 1 | One-cycle strobe that clears the limit-trip flag |
| rd_en | output | 1 | Read-side clock enable, one pulse per divide period |
| trip_flag | output | 1 | Sticky flag, set by any 15- or 17-cycle period |

## Verification
The bench uses the default parameters: a nominal divide of 16, a margin of 4, and depths of 128 and 32. With these values the thresholds 4/5 and 123/124 fall at fill levels the bench can drive exactly. In the 32 mode the thresholds 27/28 and an over-range fill of 60 also fall within reach. The bench measures each period directly, as the number of cycles between enable pulses. This lets it see the choice of ratio at the period boundary, a fill change made during a period, and the clear strobe arriving on a trip edge.

// File: rtl/jra_pkg.sv
package jra_pkg;
  typedef enum logic [1:0] {
    RATE_NOM  = 2'd0,
    RATE_FAST = 2'd1,
    RATE_SLOW = 2'd2
  } rate_e;
endpackage

// File: rtl/jra_margin_cmp.sv
module jra_margin_cmp
  import jra_pkg::*;
#(
  parameter int DEEP_BITS    = 128,
  parameter int SHALLOW_BITS = 32,
  parameter int MARGIN       = 4,
  parameter int FILL_W       = $clog2(DEEP_BITS + 1)
) (
  input  logic              deep_mode,
  input  logic [FILL_W-1:0] fill_lvl,
  output rate_e             want_rate
);
  localparam logic [FILL_W-1:0] HI_DEEP    = FILL_W'(DEEP_BITS - MARGIN);
  localparam logic [FILL_W-1:0] HI_SHALLOW = FILL_W'(SHALLOW_BITS - MARGIN);
  localparam logic [FILL_W-1:0] LO_LIM     = FILL_W'(MARGIN);

  logic [FILL_W-1:0] hi_lim;
  logic near_full, near_empty;

  always_comb begin
    hi_lim     = deep_mode ? HI_DEEP : HI_SHALLOW;
    near_full  = (fill_lvl >= hi_lim);
    near_empty = (fill_lvl <= LO_LIM);
    if (near_full)       want_rate = RATE_FAST;
    else if (near_empty) want_rate = RATE_SLOW;
    else                 want_rate = RATE_NOM;
  end
endmodule

// File: rtl/jra_period_ctr.sv
module jra_period_ctr
  import jra_pkg::*;
#(
  parameter int NOM_DIV = 16,
  parameter int CNT_W   = $clog2(NOM_DIV + 2)
) (
  input  logic  clk,
  input  logic  rst_n,
  input  rate_e want_rate,
  output logic  tick,
  output rate_e cur_rate,
  output logic  odd_load
);
  localparam logic [CNT_W-1:0] NOM_M1  = CNT_W'(NOM_DIV - 1);
  localparam logic [CNT_W-1:0] FAST_M1 = CNT_W'(NOM_DIV - 2);
  localparam logic [CNT_W-1:0] SLOW_M1 = CNT_W'(NOM_DIV);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] reload;

  always_comb begin
    unique case (want_rate)
      RATE_FAST: reload = FAST_M1;
      RATE_SLOW: reload = SLOW_M1;
      default:   reload = NOM_M1;
    endcase
  end

  assign tick     = (cnt_q == '0);
  assign odd_load = tick && (want_rate != RATE_NOM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= NOM_M1;
      cur_rate <= RATE_NOM;
    end else if (tick) begin
      cnt_q    <= reload;
      cur_rate <= want_rate;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_ratio_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cur_rate));
  assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/jra_trip_reg.sv
module jra_trip_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic trip_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     trip_o <= 1'b0;
    else if (set_i) trip_o <= 1'b1;
    else if (clr_i) trip_o <= 1'b0;
  end

  assert_trip_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trip_o && !clr_i) |=> trip_o);
  assert_trip_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !trip_o);
endmodule

// File: rtl/jitter_rate_adjuster.sv
module jitter_rate_adjuster
  import jra_pkg::*;
#(
  parameter int NOM_DIV      = 16,
  parameter int DEEP_BITS    = 128,
  parameter int SHALLOW_BITS = 32,
  parameter int MARGIN       = 4,
  parameter int FILL_W       = $clog2(DEEP_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              deep_mode,
  input  logic [FILL_W-1:0] fill_lvl,
  input  logic              trip_clr,
  output logic              rd_en,
  output logic              trip_flag
);
  rate_e want_rate, cur_rate;
  logic  odd_load;

  jra_margin_cmp #(
    .DEEP_BITS(DEEP_BITS), .SHALLOW_BITS(SHALLOW_BITS),
    .MARGIN(MARGIN), .FILL_W(FILL_W)
  ) cmp_i (
    .deep_mode(deep_mode), .fill_lvl(fill_lvl), .want_rate(want_rate)
  );

  jra_period_ctr #(.NOM_DIV(NOM_DIV)) ctr_i (
    .clk(clk), .rst_n(rst_n), .want_rate(want_rate),
    .tick(rd_en), .cur_rate(cur_rate), .odd_load(odd_load)
  );

  jra_trip_reg trip_i (
    .clk(clk), .rst_n(rst_n), .set_i(odd_load), .clr_i(trip_clr),
    .trip_o(trip_flag)
  );

  assert_trip_on_odd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && cur_rate != RATE_NOM) |-> trip_flag);
  assert_slow_when_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && fill_lvl <= FILL_W'(MARGIN)) |=> (cur_rate == RATE_SLOW));
endmodule

// File: tb/jitter_rate_adjuster_tb_top.sv
module jitter_rate_adjuster_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       deep_mode = 1'b1;
  logic [7:0] fill_lvl = 8'd64;
  logic       trip_clr = 1'b0;
  logic       rd_en, trip_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  jitter_rate_adjuster dut_i (
    .clk(clk), .rst_n(rst_n), .deep_mode(deep_mode), .fill_lvl(fill_lvl),
    .trip_clr(trip_clr), .rd_en(rd_en), .trip_flag(trip_flag)
  );

  // {deep_mode, fill, expected period, expected trip}
  localparam int NV = 12;
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 8'd64,  5'd16, 1'b0},  // R2
    {1'b1, 8'd124, 5'd15, 1'b1},  // R3
    {1'b1, 8'd123, 5'd16, 1'b0},  // R2 edge
    {1'b1, 8'd4,   5'd17, 1'b1},  // R4
    {1'b1, 8'd5,   5'd16, 1'b0},  // R2 edge
    {1'b1, 8'd0,   5'd17, 1'b1},  // R4
    {1'b1, 8'd128, 5'd15, 1'b1},  // R3
    {1'b0, 8'd28,  5'd15, 1'b1},  // R5
    {1'b0, 8'd27,  5'd16, 1'b0},  // R5
    {1'b0, 8'd4,   5'd17, 1'b1},  // R5
    {1'b0, 8'd60,  5'd15, 1'b1},  // R5 over-range
    {1'b0, 8'd16,  5'd16, 1'b0}   // R5
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rd();
    do @(negedge clk); while (!rd_en);
  endtask

  // Called at a negedge where rd_en is high; returns the next period length.
  task automatic measure(input bit clr, output int n);
    trip_clr = clr;
    @(negedge clk);
    trip_clr = 1'b0;
    n = 1;
    while (!rd_en) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check(rd_en == 1'b0, "R1 rd_en in reset", rd_en, 0);
    check(trip_flag == 1'b0, "R1 trip in reset", trip_flag, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(rd_en == 1'b0, "R1 rd_en after reset", rd_en, 0);
    check(trip_flag == 1'b0, "R1 trip after reset", trip_flag, 0);

    wait_rd();
    for (int i = 0; i < NV; i++) begin
      deep_mode = VEC[i][14];
      fill_lvl  = VEC[i][13:6];
      wait_rd();
      measure(1'b1, n);
      check(n == int'(VEC[i][5:1]), $sformatf("R3/R4/R2/R5 period vec %0d", i), n, int'(VEC[i][5:1]));
      check(trip_flag == VEC[i][0], $sformatf("R7/R8 trip vec %0d", i), trip_flag, VEC[i][0]);
    end

    // R9: pulse lasts one cycle
    @(negedge clk);
    check(rd_en == 1'b0, "R9 pulse width", rd_en, 0);

    // R6: fill change mid-period does not alter the current period
    deep_mode = 1'b1;
    fill_lvl  = 8'd64;
    wait_rd();
    wait_rd();
    @(negedge clk);
    fill_lvl = 8'd124;
    n = 1;
    while (!rd_en) begin
      @(negedge clk);
      n++;
    end
    check(n == 16, "R6 current period kept", n, 16);
    measure(1'b0, n);
    check(n == 15, "R6 next period fast", n, 15);

    // R7: sticky across nominal periods
    fill_lvl = 8'd64;
    measure(1'b0, n);
    measure(1'b0, n);
    check(n == 16, "R2 nominal after trip", n, 16);
    check(trip_flag == 1'b1, "R7 sticky", trip_flag, 1);

    // R8: mid-period clear
    @(negedge clk);
    trip_clr = 1'b1;
    @(negedge clk);
    trip_clr = 1'b0;
    check(trip_flag == 1'b0, "R8 mid clear", trip_flag, 0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule